// File: doc/BRIEF.md
# Reset Sequencer with Vector Select

This block collects the four conditions that can put the chip into reset and turns them into one stretched, active-low reset drive, plus a 2-bit code. The CPU uses that code to choose which reset vector it fetches first. The four conditions are a power-on pulse, an external reset request pin, a watchdog timeout and a clock-failure flag. The block also holds the watchdog itself: a free-running counter that software restarts with a one-cycle service strobe.

A power-on event holds reset for a long, fixed number of clock cycles. The other causes use a short, parameterised stretch. An external request keeps reset asserted for as long as the pin stays low, then adds the same short stretch. Power-on and external resets share the normal vector code. The clock-failure and watchdog resets each have their own code. The code of the winning cause is latched and held until the next reset begins.

A configuration input turns the watchdog off. It is sampled only on the clock edge at which reset releases, so its setting takes effect at once with no software action. Every countdown advances only on clock edges, so with no clock the reset never releases.

Top module: `reset_sequencer`

## Requirements
- R1: After a clock edge that samples `por_pulse_i` high, `rst_n_o` is low for exactly POR_CYCLES (default 4064) cycles, counted from the last edge that sampled the pulse high, and `vec_sel_o` is 2'b00. A pulse sampled during an ongoing reset restarts this count and forces the code to 2'b00.
- R2: When `ext_rst_n_i` is sampled low on L consecutive edges, `rst_n_o` is low for L + STRETCH_CYCLES - 1 cycles, starting on the first of those edges, and the code is 2'b00.
- R3: A single high sample of `clk_fail_i` while reset is released gives a reset of exactly STRETCH_CYCLES cycles with code 2'b01.
- R4: With the watchdog enabled and never serviced, reset asserts WDOG_LIMIT cycles after the release edge, lasts STRETCH_CYCLES cycles, and carries code 2'b10.
- R5: An edge that samples `wdog_kick_i` high restarts the watchdog, and the timeout reset then asserts WDOG_LIMIT cycles after that edge.
- R6: `wdog_off_i` is sampled only on the edge at which reset releases. A sampled 1 disables the watchdog until the next release, and a sampled 0 enables it. Changes on the input between releases have no effect.
- R7: When several causes are sampled on the same edge while reset is released, the priority is power-on, then external pin, then clock failure, then watchdog. The code and the stretch length are those of the winner.
- R8: After release, `vec_sel_o` keeps its value until the next reset begins. It never takes the value 2'b11.
- R9: The watchdog count is cleared and held at zero while reset is asserted. After any release, a full WDOG_LIMIT cycles pass before a timeout, whatever the count was before that reset.
- R10: A clock-failure or watchdog cause sampled during an ongoing reset is ignored. The code and the reset length are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock; every count advances on its rising edge |
| por_pulse_i | input | 1 | Power-on pulse, active high |
| ext_rst_n_i | input | 1 | External reset request pin, active low |
| wdog_kick_i | input | 1 | Watchdog service strobe, active high for one cycle |
| clk_fail_i | input | 1 | Clock-failure flag, active high |
| wdog_off_i | input | 1 | Watchdog disable configuration bit, sampled at release |
| rst_n_o | output | 1 | Stretched reset drive, active low |
| vec_sel_o | output | 2 | Reset vector code: 00 normal, 01 clock failure, 10 watchdog |

## Verification
The assertions take for granted that a power-on pulse arrives before anything else matters. Until then the state is undefined, so every property stays disabled until a pulse has been seen. The minimum-length property also assumes a stretch of at least two cycles, which the default provides. The bench raises the power-on pulse at time zero and keeps the default stretch. It drives every input on the falling edge so that each rising edge samples settled values. It also sets the disable bit at each release before any watchdog timing check, so no timeout can fire while another case is being measured.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [1:0] {
        VEC_NORMAL = 2'b00,
        VEC_CLKMON = 2'b01,
        VEC_WDOG   = 2'b10
    } vec_e;

    localparam int NUM_CAUSES = 4;

    // Bit 0 has the highest priority, bit 3 the lowest.
    typedef struct packed {
        logic wdog;
        logic clkmon;
        logic pin;
        logic por;
    } cause_t;

    function automatic vec_e vec_of(input int idx);
        case (idx)
            2:       return VEC_CLKMON;
            3:       return VEC_WDOG;
            default: return VEC_NORMAL;
        endcase
    endfunction

endpackage

// File: rtl/rstseq_arb.sv
module rstseq_arb
    import rstseq_pkg::*;
(
    input  cause_t cause_i,
    output logic   any_o,
    output vec_e   vec_o,
    output logic   long_o
);

    logic [NUM_CAUSES-1:0] raw;
    assign raw = cause_i;

    // Walk from lowest to highest priority so the highest one wins.
    always_comb begin
        any_o  = |raw;
        vec_o  = VEC_NORMAL;
        for (int i = NUM_CAUSES - 1; i >= 0; i--) begin
            if (raw[i]) vec_o = vec_of(i);
        end
        long_o = cause_i.por;
    end

endmodule

// File: rtl/rstseq_stretch.sv
module rstseq_stretch
    import rstseq_pkg::*;
#(
    parameter int POR_CYCLES     = 4064,
    parameter int STRETCH_CYCLES = 4
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic pin_i,
    input  logic any_i,
    input  vec_e vec_i,
    input  logic long_i,
    output logic active_o,
    output logic release_o,
    output vec_e vec_o
);

    localparam int CNT_MAX = (POR_CYCLES > STRETCH_CYCLES) ? POR_CYCLES : STRETCH_CYCLES;
    localparam int CW      = (CNT_MAX > 2) ? $clog2(CNT_MAX) : 1;
    localparam logic [CW-1:0] POR_LOAD   = CW'(POR_CYCLES - 1);
    localparam logic [CW-1:0] SHORT_LOAD = CW'(STRETCH_CYCLES - 1);
    localparam logic [CW-1:0] SHORT_CNT  = CW'(STRETCH_CYCLES);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
        vec_e          vec;
    } st_t;

    st_t st_d, st_q;
    logic rel_d;

    always_comb begin
        st_d  = st_q;
        rel_d = 1'b0;
        if (!st_q.active) begin
            if (any_i) begin
                st_d.active = 1'b1;
                st_d.vec    = vec_i;
                st_d.cnt    = long_i ? POR_LOAD : SHORT_LOAD;
            end
        end else if (por_i) begin
            st_d.cnt = POR_LOAD;
            st_d.vec = VEC_NORMAL;
        end else if (pin_i) begin
            st_d.cnt = (st_q.cnt > SHORT_CNT) ? st_q.cnt - 1'b1 : SHORT_LOAD;
        end else if (st_q.cnt == '0) begin
            st_d.active = 1'b0;
            rel_d       = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign active_o  = st_q.active;
    assign release_o = rel_d;
    assign vec_o     = st_q.vec;

endmodule

// File: rtl/rstseq_wdog.sv
module rstseq_wdog #(
    parameter int WDOG_LIMIT = 4096
) (
    input  logic clk_i,
    input  logic active_i,
    input  logic release_i,
    input  logic off_i,
    input  logic kick_i,
    output logic timeout_o
);

    localparam int CW = (WDOG_LIMIT > 2) ? $clog2(WDOG_LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(WDOG_LIMIT - 1);

    typedef struct packed {
        logic          en;
        logic [CW-1:0] cnt;
    } wd_t;

    wd_t wd_d, wd_q;

    always_comb begin
        wd_d = wd_q;
        if (release_i) wd_d.en = !off_i;
        if (active_i || !wd_q.en || kick_i || wd_q.cnt == LAST) begin
            wd_d.cnt = '0;
        end else begin
            wd_d.cnt = wd_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        wd_q <= wd_d;
    end

    assign timeout_o = wd_q.en && !active_i && !kick_i && (wd_q.cnt == LAST);

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
    import rstseq_pkg::*;
#(
    parameter int POR_CYCLES     = 4064,
    parameter int STRETCH_CYCLES = 4,
    parameter int WDOG_LIMIT     = 4096
) (
    input  logic       clk_i,
    input  logic       por_pulse_i,
    input  logic       ext_rst_n_i,
    input  logic       wdog_kick_i,
    input  logic       clk_fail_i,
    input  logic       wdog_off_i,
    output logic       rst_n_o,
    output logic [1:0] vec_sel_o
);

    cause_t cause;
    logic   any_cause, long_hold, active, release_evt, wdog_to;
    vec_e   win_vec, held_vec;

    always_comb begin
        cause.por    = por_pulse_i;
        cause.pin    = !ext_rst_n_i;
        cause.clkmon = clk_fail_i;
        cause.wdog   = wdog_to;
    end

    rstseq_arb u_arb (
        .cause_i (cause),
        .any_o   (any_cause),
        .vec_o   (win_vec),
        .long_o  (long_hold)
    );

    rstseq_stretch #(
        .POR_CYCLES     (POR_CYCLES),
        .STRETCH_CYCLES (STRETCH_CYCLES)
    ) u_stretch (
        .clk_i     (clk_i),
        .por_i     (por_pulse_i),
        .pin_i     (!ext_rst_n_i),
        .any_i     (any_cause),
        .vec_i     (win_vec),
        .long_i    (long_hold),
        .active_o  (active),
        .release_o (release_evt),
        .vec_o     (held_vec)
    );

    rstseq_wdog #(
        .WDOG_LIMIT (WDOG_LIMIT)
    ) u_wdog (
        .clk_i     (clk_i),
        .active_i  (active),
        .release_i (release_evt),
        .off_i     (wdog_off_i),
        .kick_i    (wdog_kick_i),
        .timeout_o (wdog_to)
    );

    assign rst_n_o   = !active;
    assign vec_sel_o = held_vec;

endmodule

// File: rtl/reset_sequencer_checker.sv
module reset_sequencer_checker (
    input logic       clk_i,
    input logic       por_pulse_i,
    input logic       ext_rst_n_i,
    input logic       clk_fail_i,
    input logic       rst_n_o,
    input logic [1:0] vec_sel_o
);

    logic seen_q;
    always_ff @(posedge clk_i) begin
        seen_q <= seen_q | por_pulse_i;
    end

    AST_POR_HOLD: assert property (@(posedge clk_i) disable iff (!seen_q)
        por_pulse_i |=> (!rst_n_o && vec_sel_o == 2'b00)); // R1

    AST_PIN_HOLD: assert property (@(posedge clk_i) disable iff (!seen_q)
        !ext_rst_n_i |=> !rst_n_o); // R2

    AST_CLKMON_ENTRY: assert property (@(posedge clk_i) disable iff (!seen_q)
        (rst_n_o && clk_fail_i && ext_rst_n_i && !por_pulse_i)
            |=> (!rst_n_o && vec_sel_o == 2'b01)); // R3

    AST_MIN_STRETCH: assert property (@(posedge clk_i) disable iff (!seen_q)
        $fell(rst_n_o) |=> !rst_n_o); // R3

    AST_PIN_BEATS_CLKMON: assert property (@(posedge clk_i) disable iff (!seen_q)
        (rst_n_o && !ext_rst_n_i) |=> vec_sel_o == 2'b00); // R7

    AST_VEC_HELD: assert property (@(posedge clk_i) disable iff (!seen_q)
        rst_n_o |=> (!rst_n_o || $stable(vec_sel_o))); // R8

    AST_VEC_LEGAL: assert property (@(posedge clk_i) disable iff (!seen_q)
        vec_sel_o != 2'b11); // R8

    AST_VEC_FROZEN: assert property (@(posedge clk_i) disable iff (!seen_q)
        (!rst_n_o && !por_pulse_i) |=> $stable(vec_sel_o)); // R10

endmodule

bind reset_sequencer reset_sequencer_checker u_checker (
    .clk_i       (clk_i),
    .por_pulse_i (por_pulse_i),
    .ext_rst_n_i (ext_rst_n_i),
    .clk_fail_i  (clk_fail_i),
    .rst_n_o     (rst_n_o),
    .vec_sel_o   (vec_sel_o)
);

// File: tb/reset_sequencer_bench.sv
`timescale 1ns/1ps
module reset_sequencer_bench;

    localparam int POR_N = 4064;
    localparam int S     = 4;
    localparam int LIM   = 40;

    logic clk = 1'b0;
    logic por = 1'b1;
    logic ext_n = 1'b1;
    logic kick = 1'b0;
    logic cmf = 1'b0;
    logic off = 1'b1;
    logic rst_n_o;
    logic [1:0] vec_sel_o;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    reset_sequencer #(
        .POR_CYCLES     (POR_N),
        .STRETCH_CYCLES (S),
        .WDOG_LIMIT     (LIM)
    ) u_reset_sequencer (
        .clk_i       (clk),
        .por_pulse_i (por),
        .ext_rst_n_i (ext_n),
        .wdog_kick_i (kick),
        .clk_fail_i  (cmf),
        .wdog_off_i  (off),
        .rst_n_o     (rst_n_o),
        .vec_sel_o   (vec_sel_o)
    );

    // mask bit 0 = power-on, bit 1 = pin, bit 2 = clock failure
    typedef struct packed {
        logic [2:0] mask;
        logic [7:0] len;
        logic [1:0] vec;
    } tv_t;

    localparam tv_t TBL [8] = '{
        '{3'b010, 8'd1, 2'b00},
        '{3'b010, 8'd2, 2'b00},
        '{3'b010, 8'd6, 2'b00},
        '{3'b100, 8'd1, 2'b01},
        '{3'b001, 8'd1, 2'b00},
        '{3'b110, 8'd3, 2'b00},
        '{3'b011, 8'd1, 2'b00},
        '{3'b101, 8'd1, 2'b00}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (rst_n_o == 1'b0 && n < 20000) begin
            n++;
            tick();
        end
    endtask

    task automatic count_high(output int n, input int cap);
        n = 0;
        while (rst_n_o == 1'b1 && n < cap) begin
            n++;
            tick();
        end
    endtask

    task automatic apply(input logic [2:0] m, input int len, output int total, output int v0);
        int n;
        por   = m[0];
        ext_n = !m[1];
        cmf   = m[2];
        tick();
        v0  = int'(vec_sel_o);
        por = 1'b0;
        cmf = 1'b0;
        if (m[1]) repeat (len - 1) tick();
        ext_n = 1'b1;
        count_low(n);
        total = n + (m[1] ? len - 1 : 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n, h, v, exp_n;
        string req;
        bit ok;

        // Reset state after the power-on pulse (R1)
        tick();
        por = 1'b0;
        check(rst_n_o == 1'b0 && vec_sel_o == 2'b00, "R1 reset state",
              int'(vec_sel_o), 0);
        count_low(n);
        check(n == POR_N, "R1 power-on length", n, POR_N);

        // Vector table (R1 R2 R3 R7 R8), watchdog disabled
        foreach (TBL[k]) begin
            apply(TBL[k].mask, int'(TBL[k].len), n, v);
            if (TBL[k].mask[0])      exp_n = POR_N;
            else if (TBL[k].mask[1]) exp_n = int'(TBL[k].len) + S - 1;
            else                     exp_n = S;
            if ($countones(TBL[k].mask) > 1) req = "R7";
            else if (TBL[k].mask[0])         req = "R1";
            else if (TBL[k].mask[1])         req = "R2";
            else                             req = "R3";
            check(n == exp_n, {req, " length"}, n, exp_n);
            check(v == int'(TBL[k].vec), {req, " vector"}, v, int'(TBL[k].vec));
            check(vec_sel_o == TBL[k].vec, "R8 vector after release",
                  int'(vec_sel_o), int'(TBL[k].vec));
        end

        // R6: disabled at release, later clearing of the bit ignored
        off = 1'b0;
        count_high(h, 3 * LIM);
        check(h == 3 * LIM, "R6 disabled stays quiet", h, 3 * LIM);

        // R4 / R6: enabled at release, later setting of the bit ignored
        apply(3'b100, 1, n, v);
        off = 1'b1;
        count_high(h, 10 * LIM);
        check(h == LIM, "R4 R6 timeout distance", h, LIM);
        check(vec_sel_o == 2'b10, "R4 watchdog vector", int'(vec_sel_o), 2);
        count_low(n);
        check(n == S, "R4 watchdog stretch", n, S);

        // R5: service strobe restarts the count
        off = 1'b0;
        apply(3'b100, 1, n, v);
        repeat (20) tick();
        kick = 1'b1;
        tick();
        kick = 1'b0;
        count_high(h, 10 * LIM);
        check(h == LIM, "R5 timeout after kick", h, LIM);
        count_low(n);

        // R9: count cleared by an intervening reset
        repeat (15) tick();
        apply(3'b100, 1, n, v);
        check(n == S, "R9 clock-fail stretch", n, S);
        count_high(h, 10 * LIM);
        check(h == LIM, "R9 full period after reset", h, LIM);
        count_low(n);

        // R7: clock failure on the same edge as the watchdog timeout
        repeat (LIM - 1) tick();
        cmf = 1'b1;
        tick();
        cmf = 1'b0;
        check(rst_n_o == 1'b0 && vec_sel_o == 2'b01, "R7 clock-fail over watchdog",
              int'(vec_sel_o), 1);
        off = 1'b1;
        count_low(n);
        check(n == S, "R7 clock-fail length", n, S);

        // R10: clock failure during a pin reset is ignored
        ext_n = 1'b0;
        tick();
        cmf = 1'b1;
        tick();
        cmf = 1'b0;
        tick();
        ext_n = 1'b1;
        count_low(n);
        check(n + 2 == 3 + S - 1, "R10 length unchanged", n + 2, 3 + S - 1);
        check(vec_sel_o == 2'b00, "R10 vector unchanged", int'(vec_sel_o), 0);

        // R1: power-on pulse restarts an ongoing clock-fail reset
        cmf = 1'b1;
        tick();
        cmf = 1'b0;
        tick();
        check(vec_sel_o == 2'b01, "R1 pre-restart vector", int'(vec_sel_o), 1);
        por = 1'b1;
        tick();
        por = 1'b0;
        check(vec_sel_o == 2'b00, "R1 restart vector", int'(vec_sel_o), 0);
        count_low(n);
        check(n == POR_N, "R1 restart length", n, POR_N);

        // R8: vector holds while released
        ok = 1'b1;
        for (int i = 0; i < 10; i++) begin
            ok &= (vec_sel_o == 2'b00) && rst_n_o;
            tick();
        end
        check(ok, "R8 vector held", int'(vec_sel_o), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule